// File: doc/BRIEF.md
# Packet CRC-16 Inserter and Word Packer

This block sits on the transmit side of a serial packet link. A packet enters as a stream of 16-bit halfwords: one header halfword, the 16-bit destination identifier, the 16-bit source identifier, and then the payload halfwords. The final input halfword is flagged with `in_last`. The block passes these halfwords through unchanged. It adds a running CRC-16 at the points the link format requires and packs the result into 32-bit words. In each word the earlier halfword goes in the upper half.

The top five bits of the header halfword hold the link acknowledge identifier. That field is rewritten hop by hop, so it is treated as zero for the CRC but is still transmitted as received. A packet carrying more than 37 payload halfwords gets an intermediate CRC after its 37th payload halfword. That intermediate value is then fed back into the running CRC. Every packet ends with a final CRC halfword. A zero halfword follows it when needed so the frame ends on a 32-bit boundary.

Both sides use a valid/ready handshake. A packet that ends before its source identifier has arrived is discarded, and a one-cycle error pulse is raised.

Top module: `crc_frame_packer`

## Requirements
- R1: After reset, `out_valid` and `err` are low and `in_ready` is high.
- R2: Input halfwords leave in arrival order, two per output word. The earlier halfword is in bits 31:16 and the later one in bits 15:0.
- R3: The CRC uses polynomial 0x1021 and is seeded with 0xFFFF at the start of each packet. It is updated once per halfword, most significant bit first, so the high byte is taken before the low byte.
- R4: Bits 15:11 of the first halfword (the acknowledge identifier) are replaced by zeros for the CRC, but are output unchanged. Two packets that differ only in those bits carry the same CRC.
- R5: With at most 37 payload halfwords, exactly one CRC halfword follows the last payload halfword.
- R6: With more than 37 payload halfwords, the current CRC is inserted right after the 37th payload halfword, at halfword position 41 counting from 1. The running CRC is then updated with that inserted value as if it were data, and the final CRC follows the last payload halfword.
- R7: If the halfword count up to and including the final CRC is odd, one 0x0000 halfword is appended. A 133-halfword payload therefore yields 69 words.
- R8: `out_last` is high only on the final word of a frame. That word holds either the final CRC or the padding halfword.
- R9: A packet whose `in_last` arrives on its first or second halfword produces no output word. It raises `err` for one cycle, in the cycle after the last halfword is accepted. The next packet is framed normally.
- R10: While `out_valid` is high and `out_ready` is low, `out_data` and `out_last` hold their values, and no halfword is lost or duplicated under any pattern of stalls on either side.
- R11: With `out_ready` held high and no input gaps, one halfword is accepted per clock. The only exceptions are a one-cycle gap for the intermediate CRC and the cycles that close out the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input halfword valid |
| in_ready | output | 1 | Block can accept a halfword |
| in_data | input | 16 | Input halfword |
| in_last | input | 1 | Marks the final halfword of a packet |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the word |
| out_data | output | 32 | Packed output word |
| out_last | output | 1 | Final word of the frame |
| err | output | 1 | Pulse: packet too short, dropped |

## Verification
A corrupted CRC register shows up as a wrong CRC halfword at the end of the current frame, or at the intermediate slot of a long frame. A wrong halfword-parity flag swaps halves or misplaces padding from the next word onward. A wrong position counter moves the intermediate CRC or changes the frame length. That error becomes visible in the frame's word count and in the position of `out_last`, or in the word holding position 41. A sweep over every payload length from 0 to 133, run with and without random stalls, covers each of these in the first affected frame.

// File: rtl/crc_frame_packer.sv
module crc_frame_packer #(
  parameter int          HW         = 16,
  parameter int          MID_PAYLD  = 37,
  parameter int          TAG_BITS   = 5,
  parameter logic [15:0] POLY       = 16'h1021,
  parameter logic [15:0] SEED       = 16'hFFFF,
  parameter int          CNT_W      = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [HW-1:0]   in_data,
  input  logic            in_last,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [2*HW-1:0] out_data,
  output logic            out_last,
  output logic            err
);
  localparam int HDR_N   = 3;
  localparam int MID_IDX = HDR_N + MID_PAYLD - 1;
  localparam logic [HW-1:0] TAG_MASK = {{TAG_BITS{1'b0}}, {(HW-TAG_BITS){1'b1}}};

  typedef enum logic [1:0] {S_DATA, S_MID, S_FIN, S_PAD} st_t;

  st_t            st;
  logic           hi_pend;
  logic [HW-1:0]  hi_reg;
  logic [HW-1:0]  crc;
  logic [CNT_W-1:0] in_cnt;

  function automatic logic [HW-1:0] crc_step(input logic [HW-1:0] c, input logic [HW-1:0] d);
    logic [HW-1:0] r;
    r = c;
    for (int i = HW - 1; i >= 0; i--)
      r = {r[HW-2:0], 1'b0} ^ ((r[HW-1] ^ d[i]) ? POLY : '0);
    return r;
  endfunction

  logic          can_emit, acc, bad, emit;
  logic [HW-1:0] emit_h, crc_in;

  assign can_emit = !hi_pend || !out_valid || out_ready;
  assign in_ready = (st == S_DATA) && can_emit;
  assign acc      = in_valid && in_ready;
  assign bad      = acc && in_last && (in_cnt < CNT_W'(HDR_N - 1));
  assign emit     = (acc && !bad) || ((st != S_DATA) && can_emit);
  assign emit_h   = (st == S_DATA) ? in_data : (st == S_PAD) ? '0 : crc;
  assign crc_in   = (in_cnt == '0) ? (in_data & TAG_MASK) : in_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_DATA;
      hi_pend   <= 1'b0;
      hi_reg    <= '0;
      crc       <= SEED;
      in_cnt    <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
      err       <= 1'b0;
    end else begin
      err <= bad;
      if (out_valid && out_ready) out_valid <= 1'b0;

      if (emit) begin
        if (!hi_pend) begin
          hi_pend <= 1'b1;
          hi_reg  <= emit_h;
        end else begin
          hi_pend   <= 1'b0;
          out_valid <= 1'b1;
          out_data  <= {hi_reg, emit_h};
          out_last  <= (st == S_FIN) || (st == S_PAD);
        end
      end

      unique case (st)
        S_DATA: if (acc) begin
          if (bad) begin
            hi_pend <= 1'b0;
            crc     <= SEED;
            in_cnt  <= '0;
          end else begin
            crc <= crc_step(crc, crc_in);
            if (in_cnt != '1) in_cnt <= in_cnt + 1'b1;
            if (in_last)                         st <= S_FIN;
            else if (in_cnt == CNT_W'(MID_IDX))  st <= S_MID;
          end
        end
        S_MID: if (can_emit) begin
          crc <= crc_step(crc, crc);
          st  <= S_DATA;
        end
        S_FIN: if (can_emit) begin
          crc    <= SEED;
          in_cnt <= '0;
          st     <= hi_pend ? S_DATA : S_PAD;
        end
        S_PAD: if (can_emit) st <= S_DATA;
        default: st <= S_DATA;
      endcase
    end
  end

  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  // R9
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(in_valid && in_last));

  // R5
  crc_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && in_ready && in_last && (in_cnt >= CNT_W'(HDR_N - 1))) |-> !in_ready);

  // R8
  last_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |-> !hi_pend);

  // R6
  mid_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !in_last && (in_cnt == CNT_W'(MID_IDX))) |=> !in_ready);
endmodule

// File: tb/crc_frame_packer_tb_top.sv
`timescale 1ns/1ps
module crc_frame_packer_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b1;
  logic [15:0] in_data = '0;
  logic in_ready, out_valid, out_last, err;
  logic [31:0] out_data;

  always #2.5 clk = ~clk;

  crc_frame_packer dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_last(out_last), .err(err));

  int n_cmp = 0, n_bad = 0, n_cyc = 0;
  logic [31:0] last_rx;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [15:0] upd(input logic [15:0] c, input logic [15:0] d);
    logic [15:0] r = c;
    for (int b = 15; b >= 0; b--) begin
      logic fb = r[15] ^ d[b];
      r = r << 1;
      if (fb) r = r ^ 16'h1021;
    end
    return r;
  endfunction

  always @(posedge clk) begin
    n_cyc++;
    if (n_cyc > 190000) begin
      n_bad++;
      $display("FAIL watchdog: got %0d cycles expected completion", n_cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic run_pkt(input int plen, input logic [4:0] ack, input bit stall, input int seed);
    logic [15:0] hw [0:135];
    logic [15:0] eh [0:139];
    string tg [0:69];
    int n, ne, nw, idx, got, cyc, first, lasta, pos41;
    logic [15:0] c;
    logic hold;
    logic [31:0] hold_d;
    n = 3 + plen;
    hw[0] = {ack, 1'b0, 10'(seed * 37 + plen)};
    for (int i = 1; i < n; i++) hw[i] = 16'(seed * 40503 + i * 9973 + plen * 311);
    c = 16'hFFFF; ne = 0; pos41 = -1;
    for (int i = 0; i < n; i++) begin
      eh[ne] = hw[i]; ne++;
      c = upd(c, (i == 0) ? {5'b0, hw[i][10:0]} : hw[i]);
      if (i == 39 && n > 40) begin
        eh[ne] = c; pos41 = ne; ne++;
        c = upd(c, c);
      end
    end
    eh[ne] = c; ne++;
    if (ne % 2 == 1) begin eh[ne] = 16'h0000; ne++; end
    nw = ne / 2;
    for (int k = 0; k < nw; k++)
      tg[k] = (k == nw - 1) ? "R3/R5/R7" : (pos41 >= 0 && k == pos41 / 2) ? "R6" : (k == 0) ? "R4" : "R2";
    idx = 0; got = 0; cyc = 0; first = -1; lasta = -1; hold = 1'b0; hold_d = '0;
    while ((idx < n || got < nw) && cyc < 3000) begin
      @(posedge clk); #1;
      out_ready = stall ? (($urandom % 3) != 0) : 1'b1;
      in_valid  = (idx < n) && (stall ? (($urandom % 4) != 0) : 1'b1);
      in_data   = hw[(idx < n) ? idx : 0];
      in_last   = (idx == n - 1);
      @(negedge clk);
      if (hold) check("R10 hold", {out_valid, out_data[30:0]} ^ {1'b0, 31'(0)}, {1'b1, hold_d[30:0]});
      if (out_valid && out_ready) begin
        if (got < nw) begin
          check(tg[got], out_data, {eh[2*got], eh[2*got+1]});
          check("R8 last", {31'b0, out_last}, {31'b0, got == nw - 1});
          last_rx = out_data;
        end
        got++;
      end
      hold = out_valid && !out_ready; hold_d = out_data;
      if (in_valid && in_ready) begin
        if (first < 0) first = cyc;
        lasta = cyc; idx++;
      end
      cyc++;
    end
    @(posedge clk); #1; in_valid = 1'b0; in_last = 1'b0; out_ready = 1'b1;
    @(negedge clk);
    check("R7 word count", got, nw);
    check("R7 no extra word", {31'b0, out_valid}, 32'd0);
    if (!stall) check("R11 span", lasta - first, n - 1 + ((n > 40) ? 1 : 0));
  endtask

  task automatic bad_pkt(input int k);
    bit seen_out = 0;
    for (int i = 0; i < k; i++) begin
      @(posedge clk); #1;
      in_valid = 1'b1; in_data = 16'hA000 + 16'(i); in_last = (i == k - 1); out_ready = 1'b1;
      @(negedge clk);
      if (out_valid) seen_out = 1;
      check("R9 err early", {31'b0, err}, 32'd0);
    end
    @(posedge clk); #1; in_valid = 1'b0; in_last = 1'b0;
    @(negedge clk);
    check("R9 err pulse", {31'b0, err}, 32'd1);
    if (out_valid) seen_out = 1;
    @(posedge clk); #1;
    @(negedge clk);
    check("R9 err one cycle", {31'b0, err}, 32'd0);
    if (out_valid) seen_out = 1;
    check("R9 no output", {31'b0, seen_out}, 32'd0);
  endtask

  initial begin
    logic [31:0] crc_a;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1 out_valid", {31'b0, out_valid}, 32'd0);
    check("R1 err", {31'b0, err}, 32'd0);
    check("R1 in_ready", {31'b0, in_ready}, 32'd1);

    for (int p = 0; p <= 133; p++) run_pkt(p, 5'(p), 1'b0, p + 1);
    for (int p = 0; p <= 133; p++) run_pkt(p, 5'(31 - p), 1'b1, p + 7);

    run_pkt(20, 5'd0, 1'b0, 99);  crc_a = last_rx;
    run_pkt(20, 5'd31, 1'b0, 99);
    check("R4 ackID excluded", last_rx, crc_a);
    run_pkt(60, 5'd0, 1'b1, 5);   crc_a = last_rx;
    run_pkt(60, 5'd21, 1'b1, 5);
    check("R4 ackID excluded long", last_rx, crc_a);

    bad_pkt(1);
    run_pkt(3, 5'd9, 1'b0, 11);
    bad_pkt(2);
    run_pkt(38, 5'd4, 1'b0, 12);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule